// File: doc/BRIEF.md
# Buffered Configuration Port Sequencer

This block connects a simple host register port to an internal configuration access port. The host loads words into a small local buffer. It then writes a command word that names a direction and a word count. On a write command the sequencer streams buffer entries to the port as one unbroken burst. On a read command it captures words coming back from the port into the buffer, starting at entry 0. The host polls a status register for completion and then reads the captured words out of the buffer.

The port has active-low enable and write strobes, and a busy input that stalls the transfer. While enable is low the write strobe never moves, because a change would abort the port's transfer. Every direction change is made in a setup cycle in which enable is still high. An optional per-byte bit reversal adapts the host's bit order to the port's bit order, on both the outgoing and the incoming path. A read that sees busy for a programmable run of cycles is abandoned and flagged.

The controller is a four-state machine:
- IDLE: strobes inactive, waiting for a command.
- SETUP: enable stays high while the write strobe takes its new level.
- XWR: write burst.
- XRD: read burst.

The transitions are:
- IDLE to SETUP when a command is accepted.
- SETUP to XWR or XRD, according to the opcode.
- XWR to IDLE when the last word is accepted.
- XRD to IDLE either when the last word is captured or when the busy-run limit expires.

Top module: `cfgport_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves `port_cs_n` and `port_wr_n` high, clears the status register to 0 and sets the busy-run limit register to its default of 16.
- R2: `port_cs_n` and `port_wr_n` are active low. `port_wr_n` never changes in a cycle where `port_cs_n` was low in the previous cycle and is still low. Each burst is preceded by at least one cycle with `port_cs_n` high that already carries the burst's write-strobe level.
- R3: The command register (address 8) takes an opcode in bits [31:30] and a count in bits [3:0]. Opcode 2'b10 means write and 2'b01 means read. A command whose opcode is any other value, or whose count is 0 or greater than the buffer depth (8), is ignored.
- R4: A write burst presents buffer entries 0 to count-1 in order on `port_din` with `port_wr_n` low. With `port_busy` low throughout, the words are accepted on consecutive cycles.
- R5: While `port_busy` is high during a write, `port_din` holds the same word, `port_cs_n` stays low, and that word is presented again once busy clears.
- R6: A read burst stores each word seen on `port_dout` in a cycle with `port_busy` low into buffer entries 0 to count-1 in order, and leaves the other entries unchanged.
- R7: Configuration register (address 9) bit 0 enables reversal of bit order within each byte. This applies to words sent to the port and to words captured from the port.
- R8: Status register (address 10): bit 0 is active (a burst is in progress), bit 1 is done (the last burst finished normally), and bit 2 is timeout. Accepting a command clears bits 1 and 2.
- R9: While a burst is active, the sequencer ignores host writes to the command register, the buffer, the configuration register and the limit register.
- R10: The limit register is at address 11. A read burst that sees `port_busy` high for that many consecutive cycles stops with `port_cs_n` high and sets status bit 2. Status bit 1 is not set in that case.

Top module addresses for the default depth: the buffer occupies 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for host and port side |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host register address (buffer in lower half) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr` |
| port_cs_n | output | 1 | Active-low port enable |
| port_wr_n | output | 1 | Active-low port write strobe |
| port_din | output | 32 | Word driven into the port |
| port_dout | input | 32 | Word returned by the port |
| port_busy | input | 1 | Port stall / no-valid-data indicator |

## Verification
The bench stalls a write burst with a periodic busy pattern and confirms that every word reaches the port exactly once and in order. A design that advanced its index under busy would skip words, and one that re-fetched the word would show a changed `port_din` during the stall. It drives the port from write into read and watches the strobe on every cycle. A sequencer that flipped the write strobe in the same cycle that it lowered enable, or while enable stayed low, is reported as an abort hazard. It issues a command, a buffer write and a reversal enable while a write burst is stalled by busy. A design that accepted any of these would change the written words or the buffer contents. It runs a read into a permanently busy port and counts the enable-low cycles against the limit. An off-by-one timer would give one cycle too many or too few, and a design that also set done would leave the wrong status value.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_XWR   = 2'd2,
        ST_XRD   = 2'd3
    } cfgport_st_e;

    // register selectors inside the upper half of the host address space
    localparam logic [1:0] REG_CMD  = 2'd0;
    localparam logic [1:0] REG_CFG  = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;
    localparam logic [1:0] REG_LIM  = 2'd3;

    // command opcodes (top two bits of the command word)
    localparam logic [1:0] OP_WR = 2'b10;
    localparam logic [1:0] OP_RD = 2'b01;

endpackage

// File: rtl/cfgport_bitrev.sv
module cfgport_bitrev #(
    parameter int W = 32
) (
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NBYTES = W / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        for (genvar i = 0; i < 8; i++) begin : g_bit
            assign dout[8*b+i] = en ? din[8*b+7-i] : din[8*b+i];
        end
    end
endmodule

// File: rtl/cfgport_buf.sv
module cfgport_buf #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     hwe,
    input  logic [$clog2(DEPTH)-1:0] haddr,
    input  logic [W-1:0]             hwdata,
    output logic [W-1:0]             hrdata,
    input  logic                     cwe,
    input  logic [$clog2(DEPTH)-1:0] caddr,
    input  logic [W-1:0]             cwdata,
    output logic [W-1:0]             crdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (hwe) begin
            mem[haddr] <= hwdata;
        end else if (cwe) begin
            mem[caddr] <= cwdata;
        end
    end

    assign hrdata = mem[haddr];
    assign crdata = mem[caddr];
endmodule

// File: rtl/cfgport_tmr.sv
module cfgport_tmr #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + TW'(1);
        end
    end

    assign expire = run && (({1'b0, cnt_q} + (TW+1)'(1)) >= {1'b0, limit});
endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
    import cfgport_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 8,
    parameter int TMO_W   = 16,
    parameter int TMO_DEF = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            host_wr,
    input  logic [$clog2(DEPTH):0]          host_addr,
    input  logic [DATA_W-1:0]               host_wdata,
    output logic [DATA_W-1:0]               host_rdata,
    output logic                            port_cs_n,
    output logic                            port_wr_n,
    output logic [DATA_W-1:0]               port_din,
    input  logic [DATA_W-1:0]               port_dout,
    input  logic                            port_busy
);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int CNT_W  = IDX_W + 1;
    localparam int ADDR_W = IDX_W + 1;

    cfgport_st_e st_q, st_d;

    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic             dir_rd_q;
    logic             wr_n_q;
    logic             done_q, tmo_q, rev_q;
    logic [TMO_W-1:0] lim_q;

    logic             active, reg_sel, last, expire;
    logic [1:0]       opc;
    logic [CNT_W-1:0] cnt_in;
    logic             cmd_ok;
    logic             buf_hwe, buf_cwe;
    logic [DATA_W-1:0] buf_h, buf_c, rd_word;

    assign active  = (st_q != ST_IDLE);
    assign reg_sel = host_addr[ADDR_W-1];
    assign opc     = host_wdata[DATA_W-1 -: 2];
    assign cnt_in  = host_wdata[CNT_W-1:0];
    assign cmd_ok  = host_wr && reg_sel && (host_addr[1:0] == REG_CMD) && !active
                     && (opc == OP_WR || opc == OP_RD)
                     && (cnt_in != '0) && (cnt_in <= CNT_W'(DEPTH));
    assign last    = ({1'b0, idx_q} + CNT_W'(1)) == cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (cmd_ok) st_d = ST_SETUP;
            ST_SETUP: st_d = dir_rd_q ? ST_XRD : ST_XWR;
            ST_XWR:   if (!port_busy && last) st_d = ST_IDLE;
            ST_XRD: begin
                if (!port_busy && last)     st_d = ST_IDLE;
                else if (port_busy && expire) st_d = ST_IDLE;
            end
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q    <= '0;
            cnt_q    <= '0;
            dir_rd_q <= 1'b0;
            wr_n_q   <= 1'b1;
            done_q   <= 1'b0;
            tmo_q    <= 1'b0;
            rev_q    <= 1'b0;
            lim_q    <= TMO_W'(TMO_DEF);
        end else begin
            if (host_wr && reg_sel && !active) begin
                if (host_addr[1:0] == REG_CFG) rev_q <= host_wdata[0];
                if (host_addr[1:0] == REG_LIM) lim_q <= host_wdata[TMO_W-1:0];
            end
            if (cmd_ok) begin
                cnt_q    <= cnt_in;
                dir_rd_q <= (opc == OP_RD);
                wr_n_q   <= (opc == OP_RD);
                idx_q    <= '0;
                done_q   <= 1'b0;
                tmo_q    <= 1'b0;
            end
            if ((st_q == ST_XWR || st_q == ST_XRD) && !port_busy) begin
                if (last) begin
                    done_q <= 1'b1;
                    idx_q  <= '0;
                end else begin
                    idx_q <= idx_q + IDX_W'(1);
                end
            end
            if (st_q == ST_XRD && port_busy && expire) begin
                tmo_q <= 1'b1;
                idx_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        port_cs_n = !(st_q == ST_XWR || st_q == ST_XRD);
        port_wr_n = wr_n_q;
        buf_hwe   = host_wr && !reg_sel && !active;
        buf_cwe   = (st_q == ST_XRD) && !port_busy;
        if (!reg_sel) begin
            host_rdata = buf_h;
        end else begin
            unique case (host_addr[1:0])
                REG_CMD:  host_rdata = DATA_W'(cnt_q);
                REG_CFG:  host_rdata = DATA_W'(rev_q);
                REG_STAT: host_rdata = DATA_W'({tmo_q, done_q, active});
                REG_LIM:  host_rdata = DATA_W'(lim_q);
            endcase
        end
    end

    cfgport_buf #(.W(DATA_W), .DEPTH(DEPTH)) u_buf (
        .clk    (clk),
        .hwe    (buf_hwe),
        .haddr  (host_addr[IDX_W-1:0]),
        .hwdata (host_wdata),
        .hrdata (buf_h),
        .cwe    (buf_cwe),
        .caddr  (idx_q),
        .cwdata (rd_word),
        .crdata (buf_c)
    );

    cfgport_bitrev #(.W(DATA_W)) u_rev_out (
        .en   (rev_q),
        .din  (buf_c),
        .dout (port_din)
    );

    cfgport_bitrev #(.W(DATA_W)) u_rev_in (
        .en   (rev_q),
        .din  (port_dout),
        .dout (rd_word)
    );

    cfgport_tmr #(.TW(TMO_W)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .run    ((st_q == ST_XRD) && port_busy),
        .limit  (lim_q),
        .expire (expire)
    );

    // R1
    rst_strobe_chk: assert property (@(posedge clk)
        rst |=> (port_cs_n && port_wr_n));

    // R2
    wr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!port_cs_n && !$past(port_cs_n)) |-> $stable(port_wr_n));

    // R5
    din_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!port_cs_n && !port_wr_n && port_busy) |=> (!port_cs_n && $stable(port_din)));

    // R9
    busy_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (active && host_wr && reg_sel && host_addr[1:0] == REG_CMD) |=> $stable(cnt_q));

    // R10
    tmo_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_q) |-> $past(st_q == ST_XRD && port_busy));
endmodule

// File: tb/cfgport_ctrl_bench.sv
module cfgport_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        port_cs_n, port_wr_n;
    logic [31:0] port_din, port_dout;
    logic        port_busy = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int busy_mode = 0;
    int rd_ptr = 0;
    int wn = 0;
    int cs_low = 0;
    int viol = 0;
    logic [31:0] wlog [64];
    int          wcyc [64];
    logic        p_cs = 1'b1, p_wr = 1'b1, p_busy = 1'b0;
    logic [31:0] p_din = '0;

    localparam logic [31:0] RD_BASE = 32'h3C5A_0100;
    localparam logic [31:0] CMD_WR  = 32'h8000_0000;
    localparam logic [31:0] CMD_RD  = 32'h4000_0000;

    always #4 clk = ~clk;

    assign port_dout = RD_BASE + 32'(rd_ptr);

    cfgport_ctrl u_cfgport_ctrl (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .port_cs_n(port_cs_n), .port_wr_n(port_wr_n), .port_din(port_din),
        .port_dout(port_dout), .port_busy(port_busy)
    );

    // busy driver
    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        case (busy_mode)
            1:       port_busy = (cyc % 3 == 1);
            2:       port_busy = 1'b1;
            default: port_busy = 1'b0;
        endcase
    end

    // port model and protocol monitor
    always @(posedge clk) begin
        if (!rst) begin
            if (!port_cs_n) cs_low <= cs_low + 1;
            if (!port_cs_n && !port_wr_n && !port_busy) begin
                wlog[wn % 64] <= port_din;
                wcyc[wn % 64] <= cyc;
                wn <= wn + 1;
            end
            if (!port_cs_n && port_wr_n && !port_busy) rd_ptr <= rd_ptr + 1;
            if (!port_cs_n && !p_cs && port_wr_n != p_wr) viol <= viol + 1;
            if (!p_cs && !p_wr && p_busy && (port_cs_n || port_din != p_din)) viol <= viol + 1;
        end
        p_cs   <= port_cs_n;
        p_wr   <= port_wr_n;
        p_busy <= port_busy;
        p_din  <= port_din;
    end

    always @(posedge clk) begin
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [31:0] brev(input logic [31:0] x);
        logic [31:0] r;
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 8; i++)
                r[8*b+i] = x[8*b+7-i];
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic hr(input logic [3:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        host_addr = a;
        @(negedge clk);
        d = host_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int k = 0; k < 2000; k++) begin
            hr(4'd10, s);
            if (!s[0]) break;
        end
    endtask

    function automatic logic [31:0] wval(input int i);
        return 32'h0A0B_0C00 + 32'(i * 32'h0101_0011);
    endfunction

    task automatic t_reset();
        logic [31:0] s;
        chk(port_cs_n == 1'b1, "R1 cs_n after reset", 32'(port_cs_n), 32'd1);
        chk(port_wr_n == 1'b1, "R1 wr_n after reset", 32'(port_wr_n), 32'd1);
        hr(4'd10, s); chk(s == 32'd0, "R1 status after reset", s, 32'd0);
        hr(4'd11, s); chk(s == 32'd16, "R1 limit default", s, 32'd16);
    endtask

    task automatic t_write_burst();
        int base;
        logic [31:0] s;
        busy_mode = 0;
        for (int i = 0; i < 7; i++) hw(4'(i), wval(i));
        base = wn;
        hw(4'd8, CMD_WR | 32'd7);
        wait_idle();
        chk(wn - base == 7, "R4 burst word count", 32'(wn - base), 32'd7);
        for (int i = 0; i < 7; i++)
            chk(wlog[(base+i)%64] == wval(i), "R4 burst word order", wlog[(base+i)%64], wval(i));
        chk(wcyc[(base+6)%64] - wcyc[base%64] == 6, "R4 consecutive cycles",
            32'(wcyc[(base+6)%64] - wcyc[base%64]), 32'd6);
        hr(4'd10, s); chk(s == 32'd2, "R8 done after write", s, 32'd2);
    endtask

    task automatic t_write_stall();
        int base;
        busy_mode = 1;
        base = wn;
        hw(4'd8, CMD_WR | 32'd5);
        wait_idle();
        busy_mode = 0;
        chk(wn - base == 5, "R5 stalled word count", 32'(wn - base), 32'd5);
        for (int i = 0; i < 5; i++)
            chk(wlog[(base+i)%64] == wval(i), "R5 stalled word order", wlog[(base+i)%64], wval(i));
        chk(wcyc[(base+4)%64] - wcyc[base%64] > 4, "R5 stalls occurred",
            32'(wcyc[(base+4)%64] - wcyc[base%64]), 32'd5);
    endtask

    task automatic t_read();
        int p0;
        logic [31:0] s;
        busy_mode = 0;
        p0 = rd_ptr;
        hw(4'd8, CMD_RD | 32'd1);
        wait_idle();
        hr(4'd0, s); chk(s == RD_BASE + 32'(p0), "R6 read into entry 0", s, RD_BASE + 32'(p0));
        hr(4'd1, s); chk(s == wval(1), "R6 entry 1 untouched", s, wval(1));
        hr(4'd10, s); chk(s == 32'd2, "R8 done after read", s, 32'd2);
        chk(port_wr_n == 1'b1, "R2 wr_n read level", 32'(port_wr_n), 32'd1);
    endtask

    task automatic t_reverse();
        int base, p0;
        logic [31:0] s;
        hw(4'd9, 32'd1);
        hw(4'd0, 32'h0102_0380);
        base = wn;
        hw(4'd8, CMD_WR | 32'd1);
        wait_idle();
        chk(wlog[base%64] == brev(32'h0102_0380), "R7 reversed write", wlog[base%64], brev(32'h0102_0380));
        p0 = rd_ptr;
        hw(4'd8, CMD_RD | 32'd1);
        wait_idle();
        hr(4'd0, s);
        chk(s == brev(RD_BASE + 32'(p0)), "R7 reversed read", s, brev(RD_BASE + 32'(p0)));
        hw(4'd9, 32'd0);
    endtask

    task automatic t_timeout();
        int c0;
        logic [31:0] s;
        hw(4'd11, 32'd5);
        busy_mode = 2;
        c0 = cs_low;
        hw(4'd8, CMD_RD | 32'd2);
        wait_idle();
        busy_mode = 0;
        hr(4'd10, s); chk(s == 32'd4, "R10 timeout status", s, 32'd4);
        chk(cs_low - c0 == 5, "R10 enable cycles to timeout", 32'(cs_low - c0), 32'd5);
        chk(port_cs_n == 1'b1, "R10 enable released", 32'(port_cs_n), 32'd1);
        hw(4'd11, 32'd16);
    endtask

    task automatic t_ignore();
        int base;
        logic [31:0] s;
        for (int i = 0; i < 3; i++) hw(4'(i), wval(i + 10));
        busy_mode = 2;
        base = wn;
        hw(4'd8, CMD_WR | 32'd3);
        hr(4'd10, s); chk(s[0] == 1'b1, "R8 active during burst", s, 32'd1);
        hw(4'd0, 32'hDEAD_BEEF);
        hw(4'd8, CMD_RD | 32'd1);
        hw(4'd9, 32'd1);
        busy_mode = 0;
        wait_idle();
        chk(wn - base == 3, "R9 stalled burst count", 32'(wn - base), 32'd3);
        for (int i = 0; i < 3; i++)
            chk(wlog[(base+i)%64] == wval(i + 10), "R9 words unaffected", wlog[(base+i)%64], wval(i + 10));
        hr(4'd10, s); chk(s == 32'd2, "R9 status after ignored cmd", s, 32'd2);
        hr(4'd0, s);  chk(s == wval(10), "R9 buffer write ignored", s, wval(10));
        hr(4'd9, s);  chk(s == 32'd0, "R9 cfg write ignored", s, 32'd0);
    endtask

    task automatic t_bad_cmd();
        int c0;
        logic [31:0] s;
        c0 = cs_low;
        hw(4'd8, CMD_WR | 32'd0);
        hw(4'd8, CMD_WR | 32'd9);
        hw(4'd8, 32'hC000_0002);
        hw(4'd8, 32'h0000_0002);
        repeat (4) @(posedge clk);
        #1;
        chk(cs_low == c0, "R3 invalid commands start nothing", 32'(cs_low - c0), 32'd0);
        hr(4'd10, s); chk(s == 32'd2, "R3 status unchanged", s, 32'd2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_write_burst();
        t_write_stall();
        t_read();
        t_reverse();
        t_timeout();
        t_ignore();
        t_bad_cmd();
        chk(viol == 0, "R2 R5 strobe and hold monitor", 32'(viol), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule